// File: doc/BRIEF.md
# Repeating Alarm Sequencer with Pulse Output

This block sits behind a real-time clock's alarm comparator. Each one-cycle match strobe from the comparator is either turned into an issued alarm or dropped, depending on an alarm enable bit. A programmable repeat count sets how many further alarms follow the first one. Once that count is used up, the block clears its own enable. In chime mode the count instead wraps around, so alarms go on without end. Every issued alarm raises a one-cycle interrupt request.

A toggle flop flips on each issued alarm. This gives a square wave with 50% duty at half the alarm rate. A 2-bit select routes either that wave or an externally supplied seconds clock to the output pin.

Two resets act on the block. Power-on reset (`rst_ni`, asynchronous) clears everything. A basic device reset (`dev_rst_i`, synchronous) clears only the alarm configuration and the pending interrupt, which disables the alarm. The repeat count, the pin select and the toggle flop keep their values through it.

Top module: `alarm_seq`

## Requirements
- R1: After power-on reset: alarm enable is 0, chime is 0, the repeat count is 00h, the interrupt is 0, the pin select is 00 and the pin output is 0.
- R2: A match strobe while the enable is 1 issues an alarm. `irq_o` is 1 for exactly the one cycle after the strobe cycle.
- R3: A match strobe while the enable is 0 is ignored. It causes no interrupt, no change of the count and no change of the pin.
- R4: An issued alarm while the count is not 00h decrements the count by one.
- R5: An issued alarm while the count is 00h and chime is 0 is the final alarm, and it clears the enable. Loading N with chime off therefore yields exactly N+1 alarms.
- R6: An issued alarm while the count is 00h and chime is 1 wraps the count to FFh and leaves the enable at 1.
- R7: With pin select 00, the pin output is the toggle flop, which inverts on each issued alarm.
- R8: With pin select 01, the pin follows `sec_clk_i`. With select 10 or 11, the pin is 0.
- R9: A device reset clears the enable, chime and pending interrupt. It keeps the repeat count and the pin select.
- R10: When a repeat-count write falls in the same cycle as an issued alarm, the written value is stored and no decrement is applied. The alarm is still issued.
- R11: A configuration write that takes the enable from 0 to 1 clears the toggle flop. Writing the enable to 0 leaves the flop unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RTC domain clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| dev_rst_i | input | 1 | Basic device reset, active high, synchronous |
| match_i | input | 1 | One-cycle alarm match strobe |
| sec_clk_i | input | 1 | Seconds clock for the pin mux |
| cfg_we_i | input | 1 | Writes enable and chime |
| cfg_en_i | input | 1 | Alarm enable value to write |
| cfg_chime_i | input | 1 | Chime value to write |
| rpt_we_i | input | 1 | Writes the repeat count |
| rpt_data_i | input | 8 | Repeat count value to write |
| sel_we_i | input | 1 | Writes the pin select |
| sel_data_i | input | 2 | Pin select: 00 alarm wave, 01 seconds clock, 10/11 low |
| irq_o | output | 1 | Alarm interrupt pulse |
| pin_o | output | 1 | Selected pin output |
| alarm_en_o | output | 1 | Current alarm enable |
| chime_o | output | 1 | Current chime mode |
| rpt_cnt_o | output | 8 | Current repeat count |

## Verification
Two functions can fall in the same cycle: the software write of the repeat count and the decrement caused by an issued alarm. The bench asserts `rpt_we_i` in the cycle that carries the match strobe. It passes if the count then holds exactly the written value and the interrupt still fires. A second such case is an enable write from 0 to 1 landing on a toggle flop that an earlier alarm left high; there the bench expects the pin to drop.

// File: rtl/alarm_seq_pkg.sv
package alarm_seq_pkg;
  typedef enum logic [1:0] {
    PIN_ALARM = 2'b00,
    PIN_SEC   = 2'b01,
    PIN_LOW2  = 2'b10,
    PIN_LOW3  = 2'b11
  } pin_sel_e;
endpackage

// File: rtl/alarm_seq_ctrl.sv
module alarm_seq_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dev_rst_i,
  input  logic             match_i,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_chime_i,
  input  logic             rpt_we_i,
  input  logic [CNT_W-1:0] rpt_data_i,
  output logic             en_o,
  output logic             chime_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             issue_o,
  output logic             en_rise_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic             en_q, chime_q, irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             issue, last;

  assign issue = match_i & en_q & ~dev_rst_i;
  assign last  = issue & (cnt_q == CNT_ZERO) & ~chime_q;

  // config: device reset beats software write beats self-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      chime_q <= 1'b0;
    end else if (dev_rst_i) begin
      en_q    <= 1'b0;
      chime_q <= 1'b0;
    end else if (cfg_we_i) begin
      en_q    <= cfg_en_i;
      chime_q <= cfg_chime_i;
    end else if (last) begin
      en_q    <= 1'b0;
    end
  end

  // count: power-on reset only; zero wraps to max in chime mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= CNT_ZERO;
    else if (rpt_we_i)        cnt_q <= rpt_data_i;
    else if (issue && !last)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= issue;
  end

  assign en_o      = en_q;
  assign chime_o   = chime_q;
  assign cnt_o     = cnt_q;
  assign issue_o   = issue;
  assign en_rise_o = cfg_we_i & cfg_en_i & ~en_q & ~dev_rst_i;
  assign irq_o     = irq_q;

  // R3
  ignored_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && !en_q && !rpt_we_i) |=> (!irq_q && cnt_q == $past(cnt_q)));
  // R4
  decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && en_q && !dev_rst_i && !rpt_we_i && cnt_q != CNT_ZERO)
      |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
  // R5
  final_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && en_q && !dev_rst_i && !cfg_we_i && !chime_q && cnt_q == CNT_ZERO)
      |=> !en_q);
  // R6
  chime_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && en_q && !dev_rst_i && !cfg_we_i && !rpt_we_i && chime_q && cnt_q == CNT_ZERO)
      |=> (en_q && cnt_q == CNT_MAX));
  // R9
  dev_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_i |=> (!en_q && !chime_q && !irq_q));
  // R10
  sw_write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_we_i |=> (cnt_q == $past(rpt_data_i)));
  // R2
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q || $past(match_i));
endmodule

// File: rtl/alarm_seq_pulse.sv
module alarm_seq_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic clr_i,
  output logic wave_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tog_q <= 1'b0;
    else if (clr_i)   tog_q <= 1'b0;
    else if (issue_i) tog_q <= ~tog_q;
  end

  assign wave_o = tog_q;

  // R7
  toggle_on_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !clr_i) |=> (tog_q != $past(tog_q)));
  // R11
  enable_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tog_q);
endmodule

// File: rtl/alarm_seq_mux.sv
module alarm_seq_mux
  import alarm_seq_pkg::*;
(
  input  pin_sel_e sel_i,
  input  logic     wave_i,
  input  logic     sec_clk_i,
  output logic     pin_o
);
  always_comb begin
    unique case (sel_i)
      PIN_ALARM: pin_o = wave_i;
      PIN_SEC:   pin_o = sec_clk_i;
      default:   pin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alarm_seq.sv
module alarm_seq
  import alarm_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dev_rst_i,
  input  logic             match_i,
  input  logic             sec_clk_i,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_chime_i,
  input  logic             rpt_we_i,
  input  logic [CNT_W-1:0] rpt_data_i,
  input  logic             sel_we_i,
  input  logic [1:0]       sel_data_i,
  output logic             irq_o,
  output logic             pin_o,
  output logic             alarm_en_o,
  output logic             chime_o,
  output logic [CNT_W-1:0] rpt_cnt_o
);
  pin_sel_e sel_q;
  logic     issue, en_rise, wave;

  // pin select survives device reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= PIN_ALARM;
    else if (sel_we_i) sel_q <= pin_sel_e'(sel_data_i);
  end

  alarm_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dev_rst_i   (dev_rst_i),
    .match_i     (match_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_en_i    (cfg_en_i),
    .cfg_chime_i (cfg_chime_i),
    .rpt_we_i    (rpt_we_i),
    .rpt_data_i  (rpt_data_i),
    .en_o        (alarm_en_o),
    .chime_o     (chime_o),
    .cnt_o       (rpt_cnt_o),
    .issue_o     (issue),
    .en_rise_o   (en_rise),
    .irq_o       (irq_o)
  );

  alarm_seq_pulse u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .clr_i   (en_rise),
    .wave_o  (wave)
  );

  alarm_seq_mux u_mux (
    .sel_i     (sel_q),
    .wave_i    (wave),
    .sec_clk_i (sec_clk_i),
    .pin_o     (pin_o)
  );

  // R9
  sel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rst_i && !sel_we_i) |=> (sel_q == $past(sel_q)));
endmodule

// File: tb/alarm_seq_test.sv
module alarm_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dev_rst_i = 1'b0, match_i = 1'b0, sec_clk_i = 1'b0;
  logic       cfg_we_i = 1'b0, cfg_en_i = 1'b0, cfg_chime_i = 1'b0;
  logic       rpt_we_i = 1'b0, sel_we_i = 1'b0;
  logic [7:0] rpt_data_i = 8'h00;
  logic [1:0] sel_data_i = 2'b00;
  logic       irq_o, pin_o, alarm_en_o, chime_o;
  logic [7:0] rpt_cnt_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  alarm_seq uut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic en, input logic ch);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_en_i = en; cfg_chime_i = ch;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic wr_rpt(input logic [7:0] v);
    @(negedge clk_i); rpt_we_i = 1'b1; rpt_data_i = v;
    @(negedge clk_i); rpt_we_i = 1'b0;
  endtask

  task automatic wr_sel(input logic [1:0] v);
    @(negedge clk_i); sel_we_i = 1'b1; sel_data_i = v;
    @(negedge clk_i); sel_we_i = 1'b0;
  endtask

  // strobe one match; returns at the negedge after the capturing edge
  task automatic fire();
    @(negedge clk_i); match_i = 1'b1;
    @(negedge clk_i); match_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(alarm_en_o, 0, "R1 enable");
    chk(chime_o, 0, "R1 chime");
    chk(rpt_cnt_o, 8'h00, "R1 count");
    chk(irq_o, 0, "R1 irq");
    chk(pin_o, 0, "R1 pin");
  endtask

  task automatic t_ignore();
    logic p;
    wr_cfg(1'b0, 1'b0);
    wr_rpt(8'h03);
    p = pin_o;
    fire();
    chk(irq_o, 0, "R3 irq");
    chk(rpt_cnt_o, 8'h03, "R3 count");
    chk(pin_o, p, "R3 pin");
  endtask

  task automatic t_repeat();
    wr_rpt(8'h02);
    wr_cfg(1'b1, 1'b0);
    chk(pin_o, 0, "R11 pin after enable");
    fire();
    chk(irq_o, 1, "R2 irq raised");
    chk(rpt_cnt_o, 8'h01, "R4 count 2->1");
    chk(pin_o, 1, "R7 first toggle");
    @(negedge clk_i);
    chk(irq_o, 0, "R2 irq one cycle");
    fire();
    chk(rpt_cnt_o, 8'h00, "R4 count 1->0");
    chk(pin_o, 0, "R7 second toggle");
    fire();
    chk(irq_o, 1, "R5 final alarm irq");
    chk(alarm_en_o, 0, "R5 self clear");
    chk(pin_o, 1, "R7 third toggle");
    fire();
    chk(irq_o, 0, "R5 no fourth alarm");
    chk(pin_o, 1, "R3 pin after disable");
  endtask

  task automatic t_enable_clear();
    // pin left high by previous scenario
    wr_cfg(1'b0, 1'b0);
    chk(pin_o, 1, "R11 write 0 keeps wave");
    wr_rpt(8'h00);
    wr_cfg(1'b1, 1'b0);
    chk(pin_o, 0, "R11 rising enable clears wave");
    fire();
    chk(irq_o, 1, "R5 single alarm from 00");
    chk(alarm_en_o, 0, "R5 enable cleared after one");
  endtask

  task automatic t_chime();
    wr_rpt(8'h01);
    wr_cfg(1'b1, 1'b1);
    fire();
    chk(rpt_cnt_o, 8'h00, "R4 chime count 1->0");
    fire();
    chk(rpt_cnt_o, 8'hFF, "R6 wrap to FF");
    chk(alarm_en_o, 1, "R6 enable kept");
    fire();
    chk(rpt_cnt_o, 8'hFE, "R6 continues");
    chk(irq_o, 1, "R6 irq continues");
  endtask

  task automatic t_sel();
    wr_sel(2'b01);
    sec_clk_i = 1'b1; #1;
    chk(pin_o, 1, "R8 seconds high");
    sec_clk_i = 1'b0; #1;
    chk(pin_o, 0, "R8 seconds low");
    wr_sel(2'b10);
    sec_clk_i = 1'b1; #1;
    chk(pin_o, 0, "R8 select 10 low");
    wr_sel(2'b11); #1;
    chk(pin_o, 0, "R8 select 11 low");
    sec_clk_i = 1'b0;
  endtask

  task automatic t_devrst();
    wr_sel(2'b01);
    wr_rpt(8'h05);
    wr_cfg(1'b1, 1'b1);
    @(negedge clk_i); dev_rst_i = 1'b1;
    @(negedge clk_i); dev_rst_i = 1'b0;
    chk(alarm_en_o, 0, "R9 enable cleared");
    chk(chime_o, 0, "R9 chime cleared");
    chk(rpt_cnt_o, 8'h05, "R9 count kept");
    sec_clk_i = 1'b1; #1;
    chk(pin_o, 1, "R9 select kept");
    sec_clk_i = 1'b0;
    fire();
    chk(irq_o, 0, "R9 alarm disabled");
  endtask

  task automatic t_collide();
    wr_rpt(8'h04);
    wr_cfg(1'b1, 1'b0);
    @(negedge clk_i); match_i = 1'b1; rpt_we_i = 1'b1; rpt_data_i = 8'h09;
    @(negedge clk_i); match_i = 1'b0; rpt_we_i = 1'b0;
    chk(rpt_cnt_o, 8'h09, "R10 write wins");
    chk(irq_o, 1, "R10 alarm still issued");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ignore();
    t_repeat();
    t_enable_clear();
    t_chime();
    t_sel();
    t_devrst();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule